// File: doc/BRIEF.md
# Two-Wire Byte-Addressed EEPROM Target

This block is a 256-byte memory that answers as a target on an I2C/SMBus two-wire bus. It watches the bus through two-flop synchronisers and finds START, repeated START and STOP conditions. It answers only to its own 7-bit address, which is a base value plus a small strap input. The block drives SDA as an open-drain pin through a single enable, and it changes that enable only while SCL is low.

A write transfer loads an 8-bit byte pointer from its first data byte. Each later byte is stored at the pointer, and the pointer then steps on, wrapping through the whole array. A read transfer streams bytes from the pointer onward for as long as the controller acknowledges. A repeated START after a pointer-only write therefore gives a random-address read.

A parameter holds the power-up image. Reset reloads that image, clears the pointer and clears a sticky access flag. The SMBus pins are plain level signals with no stream handshake. The bus itself provides the flow control: the controller sets the pace through SCL and ends a read with a NACK.

Top module: `twi_eeprom_tgt`

## Requirements
- R1: The target acknowledges an address byte only when its upper 7 bits equal 0x50 plus the strap value. On any other address it leaves SDA released for the ACK bit and for every byte until the next START, and no memory content changes.
- R2: In a write transfer the first byte after the address loads the pointer. Each following byte is stored at the pointer, the pointer increments, and every byte is acknowledged with SDA low on the ninth clock.
- R3: The pointer is 8 bits and wraps from 0xFF to 0x00 on both writes and reads.
- R4: A read transfer without a preceding pointer byte returns the byte at the current pointer, MSB first, and then increments the pointer. Consecutive acknowledged bytes stream sequential locations.
- R5: A NACK from the controller (SDA high on the ninth clock of a read byte) ends the transfer. The target then keeps SDA released until the next START.
- R6: A repeated START keeps the pointer, so a write of a single pointer byte followed by a repeated START and a read returns the byte at that pointer.
- R7: Reset releases SDA, clears the pointer and the access flag, and reloads the array from the image. The default image holds (29*i + 0x11) mod 256 at location i.
- R8: The access flag is 0 after reset, is set by the first transfer whose address matches, and stays set until reset.
- R9: The SDA drive enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 3 | Added to 0x50 to form the target address |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| accessed | output | 1 | Sticky flag, set on any matched transfer |

## Verification
Most internal faults reach the bus within one byte time. A pointer that steps wrongly or skips the wrap shows up in the next byte read back. A mis-decoded address shows up as a wrong ACK level on the ninth clock of that same byte. A state machine that fails to stop after a NACK or a mismatch pulls SDA low on bits the controller reads as all ones. Faults in the image reload or the pointer clear appear in the first read after reset.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;

  localparam int BYTE_W  = 8;
  localparam int TADDR_W = 7;
  localparam int MEM_AW  = 8;
  localparam int MEM_D   = 1 << MEM_AW;
  localparam int IMG_W   = BYTE_W * MEM_D;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } phase_e;

  // Power-up image: location i holds (29*i + 0x11) mod 256.
  function automatic logic [IMG_W-1:0] default_image();
    logic [IMG_W-1:0] img;
    img = '0;
    for (int i = 0; i < MEM_D; i++) begin
      img[i*BYTE_W +: BYTE_W] = BYTE_W'(i * 29 + 17);
    end
    return img;
  endfunction

endpackage

// File: rtl/twi_pin_sync.sv
module twi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // Idle bus is high; reset the pipes high to avoid false edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_eep_array.sv
module twi_eep_array #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [DW*(1<<AW)-1:0] INIT_IMAGE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= INIT_IMAGE[i*DW +: DW];
      end
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/twi_eep_ctrl.sv
module twi_eep_ctrl
  import twi_eep_pkg::*;
#(
  parameter int AW = MEM_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_s,
  input  logic [TADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic [AW-1:0]      ptr,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               wr_en,
  output logic               sda_oe,
  output logic               accessed,
  output logic               idle,
  output logic               rd_load,
  output logic               nack_evt
);

  localparam int CNT_W    = $clog2(BYTE_W + 2);
  localparam int LAST_BIT = BYTE_W - 1;
  localparam int ACK_BIT  = BYTE_W;
  localparam int FRAME_N  = BYTE_W + 1;

  phase_e            ph;
  logic [CNT_W-1:0]  bcnt;
  logic [BYTE_W-2:0] shin;
  logic [BYTE_W-1:0] tx;
  logic              cmd_pend;
  logic              rw_bit;
  logic              m_nack;

  logic [BYTE_W-1:0] byte_in;
  logic              byte_done;
  logic              addr_hit;
  logic              ack_rise;
  logic              frame_end;

  assign byte_in   = {shin, sda_s};
  assign byte_done = scl_rise && (bcnt == CNT_W'(LAST_BIT)) &&
                     (ph == PH_ADDR || ph == PH_WRITE);
  assign addr_hit  = (byte_in[BYTE_W-1:1] == dev_addr);
  assign ack_rise  = scl_rise && (bcnt == CNT_W'(ACK_BIT));
  assign frame_end = scl_fall && (bcnt == CNT_W'(FRAME_N));

  assign wr_en    = byte_done && (ph == PH_WRITE) && !cmd_pend;
  assign wr_data  = byte_in;
  assign rd_load  = frame_end && ((ph == PH_ADDR && rw_bit) ||
                                  (ph == PH_READ && !m_nack));
  assign nack_evt = frame_end && (ph == PH_READ) && m_nack;
  assign idle     = (ph == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      bcnt     <= '0;
      shin     <= '0;
      tx       <= '0;
      ptr      <= '0;
      cmd_pend <= 1'b0;
      rw_bit   <= 1'b0;
      m_nack   <= 1'b0;
      sda_oe   <= 1'b0;
      accessed <= 1'b0;
    end else if (start_det) begin
      ph     <= PH_ADDR;
      bcnt   <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      ph     <= PH_IDLE;
      bcnt   <= '0;
      sda_oe <= 1'b0;
    end else if (ph != PH_IDLE) begin
      if (scl_rise) begin
        bcnt <= bcnt + CNT_W'(1);
        shin <= byte_in[BYTE_W-2:0];
        if (byte_done) begin
          if (ph == PH_ADDR) begin
            if (addr_hit) begin
              rw_bit   <= byte_in[0];
              accessed <= 1'b1;
            end else begin
              ph <= PH_IDLE;
            end
          end else if (cmd_pend) begin
            ptr      <= AW'(byte_in);
            cmd_pend <= 1'b0;
          end else begin
            ptr <= ptr + AW'(1);
          end
        end
        if (ack_rise && ph == PH_READ) begin
          m_nack <= sda_s;
        end
      end
      if (scl_fall) begin
        if (bcnt == CNT_W'(ACK_BIT)) begin
          // ACK slot: target drives low except on its own read bytes.
          sda_oe <= (ph != PH_READ);
        end else if (frame_end) begin
          bcnt <= '0;
          if (rd_load) begin
            ph     <= PH_READ;
            tx     <= rd_data << 1;
            sda_oe <= ~rd_data[BYTE_W-1];
            ptr    <= ptr + AW'(1);
          end else if (ph == PH_ADDR) begin
            ph       <= PH_WRITE;
            cmd_pend <= 1'b1;
            sda_oe   <= 1'b0;
          end else if (ph == PH_READ) begin
            ph     <= PH_IDLE;
            sda_oe <= 1'b0;
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (ph == PH_READ && bcnt != '0) begin
          sda_oe <= ~tx[BYTE_W-1];
          tx     <= tx << 1;
        end
      end
    end
  end

endmodule

// File: rtl/twi_eeprom_tgt.sv
module twi_eeprom_tgt
  import twi_eep_pkg::*;
#(
  parameter logic [TADDR_W-1:0] BASE_ADDR  = 7'h50,
  parameter int                 STRAP_W    = 3,
  parameter int                 SYNC_STG   = 2,
  parameter logic [IMG_W-1:0]   INIT_IMAGE = default_image()
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic               accessed
);

  logic               scl_s;
  logic               sda_s;
  logic               scl_rise;
  logic               scl_fall;
  logic               start_det;
  logic               stop_det;
  logic [TADDR_W-1:0] dev_addr;
  logic [MEM_AW-1:0]  ptr;
  logic [BYTE_W-1:0]  wr_data;
  logic [BYTE_W-1:0]  rd_data;
  logic               wr_en;
  logic               idle;
  logic               rd_load;
  logic               nack_evt;

  assign dev_addr = BASE_ADDR + TADDR_W'(strap);

  twi_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_eep_ctrl #(.AW(MEM_AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .sda_oe    (sda_oe),
    .accessed  (accessed),
    .idle      (idle),
    .rd_load   (rd_load),
    .nack_evt  (nack_evt)
  );

  twi_eep_array #(
    .AW         (MEM_AW),
    .DW         (BYTE_W),
    .INIT_IMAGE (INIT_IMAGE)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .addr  (ptr),
    .wdata (wr_data),
    .rdata (rd_data)
  );

endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          accessed,
  input logic          idle,
  input logic          wr_en,
  input logic          rd_load,
  input logic          nack_evt,
  input logic [AW-1:0] ptr
);

  AST_RST_QUIET: assert property (@(posedge clk) !rst_n |=> (!sda_oe && !accessed)); // R7

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe); // R1

  AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    accessed |=> accessed); // R8

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + AW'(1))); // R2

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (ptr == $past(ptr) + AW'(1))); // R4

  AST_NACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> idle); // R5

endmodule

bind twi_eeprom_tgt twi_eeprom_chk #(.AW(twi_eep_pkg::MEM_AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .accessed (accessed),
  .idle     (idle),
  .wr_en    (wr_en),
  .rd_load  (rd_load),
  .nack_evt (nack_evt),
  .ptr      (ptr)
);

// File: tb/twi_eeprom_tgt_tb_top.sv
`timescale 1ns/1ps
module twi_eeprom_tgt_tb_top;

  localparam int Q  = 8;
  localparam int NV = 12;

  typedef struct packed {
    logic [1:0] op;   // 0 single write, 1 random read, 2 current read
    logic [6:0] dev;
    logic [7:0] ptr;
    logic [7:0] dat;
    logic       ack;  // expected address ACK
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h55, 8'h10, 8'hA7, 1'b1},
    '{2'd1, 7'h55, 8'h10, 8'h00, 1'b1},
    '{2'd0, 7'h50, 8'h20, 8'h3C, 1'b0},
    '{2'd1, 7'h55, 8'h20, 8'h00, 1'b1},
    '{2'd2, 7'h55, 8'h00, 8'h00, 1'b1},
    '{2'd2, 7'h55, 8'h00, 8'h00, 1'b1},
    '{2'd0, 7'h55, 8'hFF, 8'h5A, 1'b1},
    '{2'd2, 7'h55, 8'h00, 8'h00, 1'b1},
    '{2'd1, 7'h57, 8'h10, 8'h00, 1'b0},
    '{2'd1, 7'h55, 8'hFF, 8'h00, 1'b1},
    '{2'd0, 7'h56, 8'h30, 8'h99, 1'b0},
    '{2'd2, 7'h55, 8'h00, 8'h00, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic accessed;
  logic sda_bus;
  logic [2:0] strap = 3'd5;

  int n_chk = 0;
  int n_fail = 0;
  int scl_viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] model [256];
  logic [7:0] mptr;

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  twi_eeprom_tgt dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap    (strap),
    .scl_i    (m_scl),
    .sda_i    (sda_bus),
    .sda_oe   (sda_oe),
    .accessed (accessed)
  );

  // R9 monitor: drive enable must not move while the controller holds SCL high
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && m_scl) scl_viol++;
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~give_ack);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    for (int i = 0; i < 256; i++) model[i] = 8'(i * 29 + 17);
    mptr = 8'h00;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic a, a2, a3;
    logic [7:0] d;
    vec_t v;

    do_reset();
    // R7: released bus and cleared flag after reset
    chk("R7 oe", {7'd0, sda_oe}, 8'd0);
    chk("R7 accessed", {7'd0, accessed}, 8'd0);

    // R1/R8: foreign address is ignored and does not set the flag
    bus_start();
    send_byte({7'h52, 1'b0}, a);
    bus_stop();
    chk("R1 foreign ack", {7'd0, a}, 8'd0);
    chk("R8 no set", {7'd0, accessed}, 8'd0);

    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      case (v.op)
        2'd0: begin
          bus_start();
          send_byte({v.dev, 1'b0}, a);
          chk("R1 addr ack", {7'd0, a}, {7'd0, v.ack});
          send_byte(v.ptr, a2);
          send_byte(v.dat, a3);
          bus_stop();
          if (v.ack) begin
            chk("R2 data ack", {6'd0, a2, a3}, 8'd3);
            model[v.ptr] = v.dat;
            mptr = v.ptr + 8'd1;
          end else begin
            chk("R1 silent", {6'd0, a2, a3}, 8'd0);
          end
        end
        2'd1: begin
          bus_start();
          send_byte({v.dev, 1'b0}, a);
          chk("R1 addr ack", {7'd0, a}, {7'd0, v.ack});
          if (v.ack) begin
            send_byte(v.ptr, a2);
            bus_start();
            send_byte({v.dev, 1'b1}, a3);
            recv_byte(1'b0, d);
            bus_stop();
            chk("R6 random read", d, model[v.ptr]);
            mptr = v.ptr + 8'd1;
          end else begin
            bus_stop();
          end
        end
        default: begin
          bus_start();
          send_byte({v.dev, 1'b1}, a);
          recv_byte(1'b0, d);
          bus_stop();
          chk("R4 current read", d, model[mptr]);
          mptr = mptr + 8'd1;
        end
      endcase
    end
    chk("R8 sticky", {7'd0, accessed}, 8'd1);

    // R2/R3: burst write across the top of the array
    bus_start();
    send_byte({7'h55, 1'b0}, a);
    send_byte(8'hFE, a);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'h11 * (i + 1), a);
      chk("R2 burst ack", {7'd0, a}, 8'd1);
      model[8'(8'hFE + i)] = 8'(8'h11 * (i + 1));
    end
    bus_stop();

    // R3/R4/R6: streamed random read across the wrap
    bus_start();
    send_byte({7'h55, 1'b0}, a);
    send_byte(8'hFE, a);
    bus_start();
    send_byte({7'h55, 1'b1}, a);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, d);
      chk("R3 wrap read", d, model[8'(8'hFE + i)]);
    end
    // R5: after NACK the target stays off the bus
    chk("R5 released", {7'd0, sda_oe}, 8'd0);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_in(a);
    chk("R5 silent byte", d, 8'hFF);
    bus_stop();
    bus_start();
    send_byte({7'h55, 1'b1}, a);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R4 next after wrap", d, model[8'h02]);

    // R2: pointer-only write, then current read
    bus_start();
    send_byte({7'h55, 1'b0}, a);
    send_byte(8'h40, a);
    bus_stop();
    bus_start();
    send_byte({7'h55, 1'b1}, a);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R2 pointer load", d, model[8'h40]);

    // R7: reset reloads the image and clears pointer and flag
    do_reset();
    chk("R7 accessed", {7'd0, accessed}, 8'd0);
    bus_start();
    send_byte({7'h55, 1'b1}, a);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R7 pointer zero", d, 8'h11);
    bus_start();
    send_byte({7'h55, 1'b0}, a);
    send_byte(8'hFE, a);
    bus_start();
    send_byte({7'h55, 1'b1}, a);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R7 image reload", d, 8'(254 * 29 + 17));

    chk("R9 scl high changes", 8'(scl_viol), 8'd0);
    tick(10);
    finish_run();
  end

endmodule